// File: doc/BRIEF.md
# Fixed-Priority Interrupt Vector Unit

This unit sits beside a small processor core and decides which pending event the core should service next. It takes one reset request and a parameterised set of interrupt lines. Each line is latched into a pending flag. An interrupt line counts as eligible only when its own enable bit and the global interrupt enable are both set. When the core is running outside the boot section and the lock input is high, every interrupt line is held off. The reset request passes all of these gates.

Among the eligible requests, the one with the lowest vector index wins. The reset request has index 0 and interrupt line k has index k+1. Each vector slot is two words wide. The unit registers a request-valid strobe and the program-memory address of the winner's vector. A table-select input moves the interrupt vectors from address zero to a boot-section base; the reset vector never moves. An acknowledge from the core clears the winner's pending flag and also clears the global enable. A return-from-interrupt pulse sets the global enable again.

Top module: `ivu_top`

## Requirements
- R1: While reset is applied and on the first cycle after it, `req_valid` is 0, `vec_addr` is 0 and `gie` is 0.
- R2: A request that is high for a single cycle is latched as pending and is presented later, once its enables allow it.
- R3: Interrupt line k is presented only when `src_en[k]` and `gie` are both 1. Otherwise `req_valid` stays 0 for that line.
- R4: Among eligible requests, the lowest index wins. The vector address is base + 2*index, where line k has index k+1 (with base 0, line 2 gives 6 and line 5 gives 12).
- R5: `reset_req` is presented with vector address 0 whatever the state of `gie`, `src_en`, `lock_in` and `vec_sel`, and it outranks every interrupt line.
- R6: With `vec_sel` = 1 the interrupt base is BOOT_BASE (default 0xE00), so line 1 gives 0xE04.
- R7: With `lock_in` = 1 and `pc` below BOOT_BASE, no interrupt line is presented. With `pc` at or above BOOT_BASE, interrupt lines are presented normally.
- R8: An `ack` while `req_valid` is 1 clears `gie` and the winner's pending flag. Lower-priority flags stay pending.
- R9: A `reti` pulse sets `gie` on the next edge, unless an accepted `ack` falls in the same cycle.
- R10: `req_valid` and `vec_addr` are registered and reflect the sampled inputs one edge later. While no request is presented, `vec_addr` holds its last value.
- R11: An `ack` while `req_valid` is 0 has no effect on `gie` or `vec_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_req | input | 1 | Unmaskable reset request |
| irq_in | input | NUM_SRC | Interrupt request lines, latched on assertion |
| src_en | input | NUM_SRC | Per-line enable bits |
| vec_sel | input | 1 | 1 places interrupt vectors at BOOT_BASE |
| lock_in | input | 1 | Holds off interrupts while pc is below BOOT_BASE |
| pc | input | PC_W | Current program counter of the core |
| ack | input | 1 | Core accepts the presented vector |
| reti | input | 1 | Return-from-interrupt pulse, sets gie |
| req_valid | output | 1 | A vector is being presented |
| vec_addr | output | PC_W | Registered vector address |
| gie | output | 1 | Global interrupt enable state |

## Verification
The outputs `req_valid`, `vec_addr` and `gie` all change on the edge that samples the causing input (a raised line, a change of enable, `reti` or `ack`). So each result is due exactly one edge after its stimulus. The bench drives inputs on the falling edge and checks the outputs on the next falling edge, half a period after the register has updated. For the "no effect" and "hold" cases, the bench observes the outputs for extra cycles after the stimulus and before the next one.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  localparam int SLOT_WORDS = 2;

  function automatic int slot_offset(input int idx);
    return idx * SLOT_WORDS;
  endfunction

  function automatic logic below_boot(input logic [31:0] pc_v, input logic [31:0] base_v);
    return pc_v < base_v;
  endfunction
endpackage

// File: rtl/ivu_flags.sv
module ivu_flags #(
  parameter int N1 = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N1-1:0] set_v,
  input  logic [N1-1:0] clr_v,
  output logic [N1-1:0] flag_nxt
);
  logic [N1-1:0] flag_q;

  generate
    for (genvar i = 0; i < N1; i++) begin : g_flag
      // a new request wins over a clear in the same cycle
      assign flag_nxt[i] = set_v[i] | (flag_q[i] & ~clr_v[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_nxt;
  end
endmodule

// File: rtl/ivu_mask.sv
module ivu_mask #(
  parameter int N1 = 9
) (
  input  logic          [N1-1:0] flag_nxt,
  input  logic          [N1-2:0] src_en,
  input  logic                   gie_nxt,
  input  logic                   blocked,
  output logic          [N1-1:0] req_eff
);
  assign req_eff[0] = flag_nxt[0];

  generate
    for (genvar i = 1; i < N1; i++) begin : g_gate
      assign req_eff[i] = flag_nxt[i] & src_en[i-1] & gie_nxt & ~blocked;
    end
  endgenerate
endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
  parameter int N1 = 9,
  localparam int IW = (N1 > 1) ? $clog2(N1) : 1
) (
  input  logic [N1-1:0] req_eff,
  output logic [N1-1:0] grant,
  output logic [IW-1:0] win_idx,
  output logic          any
);
  always_comb begin
    win_idx = '0;
    for (int i = N1 - 1; i >= 0; i--) begin
      if (req_eff[i]) win_idx = IW'(i);
    end
  end

  assign any   = |req_eff;
  assign grant = any ? (N1'(1) << win_idx) : '0;
endmodule

// File: rtl/ivu_top.sv
module ivu_top #(
  parameter int NUM_SRC   = 8,
  parameter int PC_W      = 12,
  parameter int BOOT_BASE = 'hE00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               vec_sel,
  input  logic               lock_in,
  input  logic [PC_W-1:0]    pc,
  input  logic               ack,
  input  logic               reti,
  output logic               req_valid,
  output logic [PC_W-1:0]    vec_addr,
  output logic               gie
);
  import ivu_pkg::*;

  localparam int N1 = NUM_SRC + 1;
  localparam int IW = (N1 > 1) ? $clog2(N1) : 1;
  localparam logic [PC_W-1:0] BOOT_PC = PC_W'(BOOT_BASE);

  logic          gie_q, gie_nxt;
  logic          valid_q;
  logic [PC_W-1:0] vec_q;
  logic [IW-1:0] win_q;
  logic          ack_take;
  logic          blocked;
  logic [N1-1:0] set_v, clr_v, flag_nxt, req_eff, grant;
  logic [IW-1:0] win_idx;
  logic          any;
  logic          any_irq;
  logic [PC_W-1:0] base_sel, vec_nxt;

  assign ack_take = ack & valid_q;
  assign gie_nxt  = ack_take ? 1'b0 : (reti ? 1'b1 : gie_q);
  assign blocked  = lock_in & below_boot(32'(pc), 32'(BOOT_PC));
  assign set_v    = {irq_in, reset_req};
  assign clr_v    = ack_take ? (N1'(1) << win_q) : '0;

  ivu_flags #(.N1(N1)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_v    (set_v),
    .clr_v    (clr_v),
    .flag_nxt (flag_nxt)
  );

  ivu_mask #(.N1(N1)) u_mask (
    .flag_nxt (flag_nxt),
    .src_en   (src_en),
    .gie_nxt  (gie_nxt),
    .blocked  (blocked),
    .req_eff  (req_eff)
  );

  ivu_prio #(.N1(N1)) u_prio (
    .req_eff (req_eff),
    .grant   (grant),
    .win_idx (win_idx),
    .any     (any)
  );

  assign any_irq  = |grant[N1-1:1];
  assign base_sel = (win_idx != '0 && vec_sel) ? BOOT_PC : '0;
  assign vec_nxt  = base_sel + PC_W'(slot_offset(int'(win_idx)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q   <= 1'b0;
      valid_q <= 1'b0;
      vec_q   <= '0;
      win_q   <= '0;
    end else begin
      gie_q   <= gie_nxt;
      valid_q <= any;
      if (any) begin
        vec_q <= vec_nxt;
        win_q <= win_idx;
      end
    end
  end

  assign req_valid = valid_q;
  assign vec_addr  = vec_q;
  assign gie       = gie_q;
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker #(
  parameter int N1   = 9,
  parameter int PC_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reset_req,
  input logic            ack,
  input logic            reti,
  input logic            req_valid,
  input logic [PC_W-1:0] vec_addr,
  input logic            gie,
  input logic [N1-1:0]   grant,
  input logic            any_irq,
  input logic            gie_nxt,
  input logic            blocked
);
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_irq |-> gie_nxt);

  assert_lock_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !any_irq);

  assert_reset_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (req_valid && vec_addr == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid) |=> !gie);

  assert_reti_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && req_valid)) |=> gie);

  assert_vec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (req_valid || $stable(vec_addr)));
endmodule

bind ivu_top ivu_checker #(.N1(N1), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reset_req (reset_req),
  .ack       (ack),
  .reti      (reti),
  .req_valid (req_valid),
  .vec_addr  (vec_addr),
  .gie       (gie),
  .grant     (grant),
  .any_irq   (any_irq),
  .gie_nxt   (gie_nxt),
  .blocked   (blocked)
);

// File: tb/tb_ivu_top.sv
module tb_ivu_top;
  localparam int NS = 8;
  localparam int PW = 12;
  localparam int BB = 'hE00;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reset_req = 1'b0;
  logic [NS-1:0] irq_in = '0;
  logic [NS-1:0] src_en = '1;
  logic          vec_sel = 1'b0;
  logic          lock_in = 1'b0;
  logic [PW-1:0] pc = '0;
  logic          ack = 1'b0;
  logic          reti = 1'b0;
  logic          req_valid;
  logic [PW-1:0] vec_addr;
  logic          gie;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ivu_top #(.NUM_SRC(NS), .PC_W(PW), .BOOT_BASE(BB)) dut (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .irq_in(irq_in),
    .src_en(src_en), .vec_sel(vec_sel), .lock_in(lock_in), .pc(pc),
    .ack(ack), .reti(reti), .req_valid(req_valid), .vec_addr(vec_addr), .gie(gie)
  );

  function automatic int exp_vec(input int line, input bit boot);
    return (boot ? BB : 0) + 2 * (line + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_reti();
    reti = 1'b1; step(); reti = 1'b0;
  endtask

  task automatic raise(input int line);
    irq_in[line] = 1'b1; step(); irq_in[line] = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", int'(req_valid), 0);
    check("R1 vec", int'(vec_addr), 0);
    check("R1 gie", int'(gie), 0);
  endtask

  task automatic t_latch();
    raise(0);
    check("R3 no gie", int'(req_valid), 0);
    step(3);
    check("R3 still idle", int'(req_valid), 0);
    do_reti();
    check("R9 gie set", int'(gie), 1);
    check("R2 latched valid", int'(req_valid), 1);
    check("R2 latched vec", int'(vec_addr), exp_vec(0, 0));
    do_ack();
    check("R8 valid drop", int'(req_valid), 0);
    check("R8 gie clr", int'(gie), 0);
    step(2);
    check("R10 vec hold", int'(vec_addr), exp_vec(0, 0));
  endtask

  task automatic t_enable();
    src_en[3] = 1'b0;
    do_reti();
    raise(3);
    check("R3 src disabled", int'(req_valid), 0);
    src_en[3] = 1'b1;
    step();
    check("R3 src enabled", int'(req_valid), 1);
    check("R4 vec line3", int'(vec_addr), exp_vec(3, 0));
    do_ack();
  endtask

  task automatic t_priority();
    do_reti();
    irq_in[5] = 1'b1; irq_in[2] = 1'b1;
    step();
    irq_in = '0;
    check("R4 winner", int'(vec_addr), 6);
    do_ack();
    check("R8 after ack", int'(req_valid), 0);
    do_reti();
    check("R8 lower pending", int'(req_valid), 1);
    check("R8 lower vec", int'(vec_addr), 12);
    do_ack();
  endtask

  task automatic t_spurious();
    do_reti();
    check("R11 idle", int'(req_valid), 0);
    do_ack();
    check("R11 gie kept", int'(gie), 1);
    check("R11 vec kept", int'(vec_addr), 12);
  endtask

  task automatic t_reloc();
    vec_sel = 1'b1;
    do_reti();
    raise(1);
    check("R6 boot vec", int'(vec_addr), exp_vec(1, 1));
    check("R6 valid", int'(req_valid), 1);
    do_ack();
  endtask

  task automatic t_reset_req();
    src_en = '0; lock_in = 1'b1; pc = '0;
    reset_req = 1'b1; step(); reset_req = 1'b0;
    check("R5 valid", int'(req_valid), 1);
    check("R5 vec zero", int'(vec_addr), 0);
    do_ack();
    check("R5 cleared", int'(req_valid), 0);
    src_en = '1; lock_in = 1'b0; vec_sel = 1'b0;
  endtask

  task automatic t_lock();
    lock_in = 1'b1; pc = 12'h100;
    do_reti();
    raise(0);
    check("R7 blocked", int'(req_valid), 0);
    pc = 12'hE10;
    step();
    check("R7 in boot", int'(req_valid), 1);
    check("R7 vec", int'(vec_addr), exp_vec(0, 0));
    do_ack();
    lock_in = 1'b0;
    step(3);
    check("R10 hold idle", int'(vec_addr), exp_vec(0, 0));
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_latch();
    t_enable();
    t_priority();
    t_spurious();
    t_reloc();
    t_reset_req();
    t_lock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule